// File: doc/BRIEF.md
# Two-Dimensional Round-Robin Crossbar Scheduler

This block picks one conflict-free crossbar setting per time slot for an N-by-N input-queued switch. A request matrix arrives with a one-cycle strobe. Bit R*N+C of the matrix is set when input R holds a cell for output C. One clock later the block returns a registered allocation matrix, in the same bit layout. The allocation has at most one grant in each row and in each column, and it only grants positions that were requested.

The matrix is split into N wrap-around diagonals. Position (R, C) lies on diagonal (C - R) mod N. In each slot the diagonals are swept one after another. A diagonal grants a requested position only if no earlier diagonal in the same slot has already taken that row or that column. The sweep order rotates with a slot counter, so each diagonal leads exactly once in every run of N slots. This gives every position a first-choice turn at least once per N allocations.

Top module: `rr2d_xbar_sched`

## Requirements
- R1: After synchronous reset, alloc_valid is 0, alloc_matrix is all zeros and the first allocation uses slot 0.
- R2: Every bit set in an allocation was set in the request matrix that produced it.
- R3: Every allocation has at most one set bit per row (bits R*N..R*N+N-1) and at most one per column (bits C, N+C, ...).
- R4: alloc_valid is high exactly in the cycle after a cycle with req_valid high. While req_valid is low, alloc_matrix keeps its last value.
- R5: The slot index advances by one on each strobe and wraps from N-1 to 0. alloc_slot reports the slot used for the allocation it accompanies, and gaps without a strobe do not advance the slot.
- R6: Position (R, C) belongs to diagonal (C - R) mod N. In slot J the diagonals are applied in the order (I + J) mod N, for I = 0 up to N-1.
- R7: A position is granted exactly when it is requested and neither its row nor its column was granted by a diagonal applied earlier in the same slot.
- R8: In slot J, every requested position on diagonal J is granted.
- R9: A position requested in every strobe is granted within N consecutive allocations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request matrix strobe, one allocation per high cycle |
| req_matrix | input | N*N | Request bits, bit R*N+C means input R wants output C |
| alloc_valid | output | 1 | Allocation strobe, one cycle after req_valid |
| alloc_matrix | output | N*N | Registered grants, same layout as req_matrix |
| alloc_slot | output | max(1,clog2(N)) | Slot index used for the current allocation |

## Verification
A full request matrix must resolve to exactly the slot's leading diagonal. A scheduler that lets a later diagonal take a row or column already granted, or that gets the rotation offset wrong, produces a different permutation and fails the R6/R7 comparison. An empty matrix and single-bit matrices show any grant that was never requested. Gaps between strobes check two things: the allocation must hold its value, and the slot must not advance. A counter that runs on every clock would drift from the expected slot.

A position held high under random background traffic checks the R9 bound. A rotation that skips a diagonal would leave that position unserved for more than N allocations.

// File: rtl/rr2d_pkg.sv
package rr2d_pkg;

  // Wrap-around sum used for slot and sweep-order arithmetic
  function automatic int unsigned mod_add(int unsigned a, int unsigned b, int unsigned n);
    return (a + b) % n;
  endfunction

  // Diagonal number of matrix position (row, col)
  function automatic int unsigned diag_of(int unsigned row, int unsigned col, int unsigned n);
    return (col + n - (row % n)) % n;
  endfunction

endpackage

// File: rtl/rr2d_slot_counter.sv
module rr2d_slot_counter #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [IW-1:0] slot
);

  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [IW-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
    end else if (adv) begin
      slot_q <= (slot_q == LAST) ? '0 : slot_q + IW'(1);
    end
  end

  assign slot = slot_q;

  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (adv && slot_q == LAST) |=> (slot_q == '0)); // R5
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(slot_q)); // R5

endmodule

// File: rtl/rr2d_sweep_order.sv
module rr2d_sweep_order #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [IW-1:0]         slot,
  output logic [N-1:0][IW-1:0]  order
);

  // Step i of the sweep applies diagonal (i + slot) mod N
  for (genvar i = 0; i < N; i++) begin : g_step
    assign order[i] = IW'(rr2d_pkg::mod_add(int'(slot), i, N));
  end

endmodule

// File: rtl/rr2d_diag_stage.sv
module rr2d_diag_stage #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [IW-1:0]  pat,
  input  logic [N*N-1:0] req,
  input  logic [N-1:0]   row_busy_i,
  input  logic [N-1:0]   col_busy_i,
  output logic [N*N-1:0] grant,
  output logic [N-1:0]   row_busy_o,
  output logic [N-1:0]   col_busy_o
);

  logic [N-1:0] col_hit;

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      localparam int unsigned DIAG = rr2d_pkg::diag_of(r, c, N);
      assign grant[r*N+c] = (pat == IW'(DIAG)) && req[r*N+c]
                            && !row_busy_i[r] && !col_busy_i[c];
    end
    assign row_busy_o[r] = row_busy_i[r] | (|grant[r*N +: N]);
  end

  always_comb begin
    col_hit = '0;
    for (int r = 0; r < N; r++) begin
      col_hit = col_hit | grant[r*N +: N];
    end
  end

  assign col_busy_o = col_busy_i | col_hit;

endmodule

// File: rtl/rr2d_xbar_sched.sv
module rr2d_xbar_sched #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic [N*N-1:0] req_matrix,
  output logic           alloc_valid,
  output logic [N*N-1:0] alloc_matrix,
  output logic [IW-1:0]  alloc_slot
);

  localparam int NN = N * N;

  logic [IW-1:0]        slot;
  logic [N-1:0][IW-1:0] order;
  logic [N:0][N-1:0]    row_chain;
  logic [N:0][N-1:0]    col_chain;
  logic [N-1:0][NN-1:0] stage_grant;
  logic [NN-1:0]        grant_all;

  rr2d_slot_counter #(.N(N), .IW(IW)) slot_i (
    .clk  (clk),
    .rst  (rst),
    .adv  (req_valid),
    .slot (slot)
  );

  rr2d_sweep_order #(.N(N), .IW(IW)) order_i (
    .slot  (slot),
    .order (order)
  );

  assign row_chain[0] = '0;
  assign col_chain[0] = '0;

  for (genvar s = 0; s < N; s++) begin : g_stage
    rr2d_diag_stage #(.N(N), .IW(IW)) stage_i (
      .pat        (order[s]),
      .req        (req_matrix),
      .row_busy_i (row_chain[s]),
      .col_busy_i (col_chain[s]),
      .grant      (stage_grant[s]),
      .row_busy_o (row_chain[s+1]),
      .col_busy_o (col_chain[s+1])
    );
  end

  always_comb begin
    grant_all = '0;
    for (int s = 0; s < N; s++) begin
      grant_all = grant_all | stage_grant[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alloc_valid  <= 1'b0;
      alloc_matrix <= '0;
      alloc_slot   <= '0;
    end else begin
      alloc_valid <= req_valid;
      if (req_valid) begin
        alloc_matrix <= grant_all;
        alloc_slot   <= slot;
      end
    end
  end

  // ---------------- assertions ----------------
  function automatic logic [NN-1:0] lead_mask(logic [IW-1:0] k);
    logic [NN-1:0] m;
    m = '0;
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) begin
        if (rr2d_pkg::diag_of(r, c, N) == int'(k)) m[r*N+c] = 1'b1;
      end
    end
    return m;
  endfunction

  logic [N-1:0] rows_of_grant;
  logic [N-1:0] cols_of_grant;
  always_comb begin
    rows_of_grant = '0;
    cols_of_grant = '0;
    for (int r = 0; r < N; r++) begin
      rows_of_grant[r] = |grant_all[r*N +: N];
      cols_of_grant    = cols_of_grant | grant_all[r*N +: N];
    end
    if (!rst) begin
      AST_BUSY_ROWS: assert (row_chain[N] == rows_of_grant); // R7
      AST_BUSY_COLS: assert (col_chain[N] == cols_of_grant); // R7
    end
  end

  for (genvar r = 0; r < N; r++) begin : g_chk_row
    AST_ROW_SINGLE: assert property (@(posedge clk) disable iff (rst)
      $onehot0(alloc_matrix[r*N +: N])); // R3
  end

  for (genvar c = 0; c < N; c++) begin : g_chk_col
    logic [N-1:0] col_bits;
    for (genvar r = 0; r < N; r++) begin : g_bit
      assign col_bits[r] = alloc_matrix[r*N+c];
    end
    AST_COL_SINGLE: assert property (@(posedge clk) disable iff (rst)
      $onehot0(col_bits)); // R3
  end

  AST_GRANT_SUBSET: assert property (@(posedge clk) disable iff (rst)
    alloc_valid |-> ((alloc_matrix & ~$past(req_matrix)) == '0)); // R2
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> alloc_valid); // R4
  AST_VALID_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!alloc_valid && $stable(alloc_matrix))); // R4
  AST_LEAD_SERVED: assert property (@(posedge clk) disable iff (rst)
    alloc_valid |-> ((alloc_matrix & lead_mask(alloc_slot))
                     == ($past(req_matrix) & lead_mask(alloc_slot)))); // R8

endmodule

// File: tb/rr2d_xbar_sched_tb.sv
module rr2d_xbar_sched_tb_top;

  localparam int N  = 4;
  localparam int NN = N * N;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [NN-1:0] req_matrix = '0;
  logic          alloc_valid;
  logic [NN-1:0] alloc_matrix;
  logic [IW-1:0] alloc_slot;

  int n_cmp  = 0;
  int n_fail = 0;
  int exp_slot = 0;
  int age [NN];
  logic [NN-1:0] last_alloc = '0;

  always #4 clk = ~clk;

  rr2d_xbar_sched #(.N(N), .IW(IW)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_matrix   (req_matrix),
    .alloc_valid  (alloc_valid),
    .alloc_matrix (alloc_matrix),
    .alloc_slot   (alloc_slot)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected allocation from the diagonal sweep rules (R6, R7)
  function automatic logic [NN-1:0] model(logic [NN-1:0] m, int slot);
    logic [NN-1:0] g = '0;
    logic [N-1:0] ru = '0, cu = '0;
    for (int i = 0; i < N; i++) begin
      int k = (i + slot) % N;
      for (int r = 0; r < N; r++) begin
        int c = (r + k) % N;
        if (m[r*N+c] && !ru[r] && !cu[c]) begin
          g[r*N+c] = 1'b1;
          ru[r] = 1'b1;
          cu[c] = 1'b1;
        end
      end
    end
    return g;
  endfunction

  function automatic bit partial_perm(logic [NN-1:0] g);
    for (int r = 0; r < N; r++) begin
      int rc = 0, cc = 0;
      for (int c = 0; c < N; c++) begin
        rc += g[r*N+c];
        cc += g[c*N+r];
      end
      if (rc > 1 || cc > 1) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic [NN-1:0] diag_mask(int k);
    logic [NN-1:0] m = '0;
    for (int r = 0; r < N; r++) m[r*N + (r + k) % N] = 1'b1;
    return m;
  endfunction

  task automatic step(input bit v, input logic [NN-1:0] m);
    logic [NN-1:0] e;
    @(negedge clk);
    req_valid  = v;
    req_matrix = m;
    @(posedge clk);
    #1;
    if (v) begin
      e = model(m, exp_slot);
      check(alloc_valid === 1'b1, "R4 valid after strobe", alloc_valid, 1);
      check(alloc_slot == IW'(exp_slot), "R5 slot index", alloc_slot, exp_slot);
      check(alloc_matrix === e, "R6/R7 sweep result", alloc_matrix, e);
      check((alloc_matrix & ~m) == '0, "R2 subset of requests", alloc_matrix, alloc_matrix & m);
      check(partial_perm(alloc_matrix), "R3 one per row and column", alloc_matrix, e);
      check((alloc_matrix & diag_mask(exp_slot)) == (m & diag_mask(exp_slot)),
            "R8 leading diagonal served", alloc_matrix, m & diag_mask(exp_slot));
      for (int p = 0; p < NN; p++) begin
        if (!m[p]) age[p] = 0;
        else if (alloc_matrix[p]) age[p] = 0;
        else begin
          age[p]++;
          if (age[p] >= N) check(1'b0, "R9 starvation bound", age[p], N - 1);
        end
      end
      last_alloc = alloc_matrix;
      exp_slot = (exp_slot + 1) % N;
    end else begin
      check(alloc_valid === 1'b0, "R4 no strobe no valid", alloc_valid, 0);
      check(alloc_matrix === last_alloc, "R4 allocation held", alloc_matrix, last_alloc);
    end
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "R4 watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    foreach (age[p]) age[p] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(alloc_valid === 1'b0, "R1 reset valid", alloc_valid, 0);
    check(alloc_matrix === '0, "R1 reset matrix", alloc_matrix, 0);

    // Full matrix in slot 0 -> identity diagonal (R1, R8)
    step(1'b1, '1);
    check(last_alloc == diag_mask(0), "R1 first slot is 0", last_alloc, diag_mask(0));
    // Full matrix in slot 1 -> diagonal 1
    step(1'b1, '1);
    check(last_alloc == diag_mask(1), "R6 rotation slot 1", last_alloc, diag_mask(1));
    step(1'b0, '0);
    step(1'b0, '1);
    step(1'b1, '0);                        // empty matrix, slot 2
    check(last_alloc == '0, "R2 empty request", last_alloc, 0);
    step(1'b1, NN'(1) << (1*N + 3));       // single position, slot 3
    step(1'b1, NN'(1) << (2*N + 0));       // wraps to slot 0
    // Conflict: row 0 asks for columns 0 and 1 in slot 1 -> diag 1 wins (R7)
    step(1'b1, NN'(3));
    check(last_alloc == NN'(2), "R7 earlier diagonal wins", last_alloc, 2);

    // Random traffic with gaps; position (1,2) held high (R9)
    for (int t = 0; t < 400; t++) begin
      logic [NN-1:0] m = NN'($urandom);
      bit v = ($urandom % 5) != 0;
      m[1*N + 2] = 1'b1;
      if (!v) step(1'b0, m);
      else step(1'b1, m);
    end
    // Dense random traffic
    for (int t = 0; t < 200; t++) begin
      step(1'b1, NN'($urandom) | NN'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

endmodule